// File: doc/BRIEF.md
# RTC periodic interrupt controller

This block produces the periodic interrupt of a real-time-clock style peripheral. A free-running reference tick, one clock-wide pulse per reference period, drives a programmable countdown. A 4-bit rate code picks the countdown length. For the two fastest codes the length also depends on a 3-bit timebase field. Each time the countdown runs out, the block raises a periodic flag and, while periodic interrupts are enabled, asserts its interrupt output.

Software reaches three 8-bit registers over a simple bus that carries a register index, a write strobe and a read strobe. The registers are control (rate and timebase), enable, and status. Status collects the periodic flag and two external event flags (alarm and update) under a summary bit. Reading status clears it. Any change to the rate, and any change to the enable bit, restarts the countdown from a full period.

Top module: `rtc_pit`

## Requirements
- R1: With rate code 0 in control bits 3:0, no periodic flag is set and the interrupt stays low, whatever the reference ticks do.
- R2: Rate code c in 3..15 gives a period of REF_HZ / 2^(16-c) reference ticks, which is 8192 Hz for code 3 down to 2 Hz for code 15.
- R3: Timebase field value 3'b010 (control bits 6:4) makes codes 1 and 2 run at 256 Hz and 128 Hz. Values 3'b000 and 3'b001 make them run at 32768 Hz and 16384 Hz. Any other value keeps the previous timebase, and the timebase after reset is the fast one.
- R4: A control write stores bits 6:0, so bit 7 reads back as 0. It also restarts the countdown, and the next expiry comes after one full new period of ticks.
- R5: The countdown moves only on reference ticks, and only while enable bit 6 is set. Each expiry sets the periodic flag and asserts the interrupt. The following expiry comes one period later.
- R6: An enable write that changes bit 6 restarts the countdown. An enable write that leaves bit 6 unchanged does not. A write that clears bit 6 deasserts the interrupt and leaves the periodic flag set.
- R7: The status byte has bit 6 for periodic, bit 5 for alarm and bit 4 for update. Bit 7 is the OR of those three bits, and bits 3:0 read 0.
- R8: A status read returns the current value. After that read, status is zero and the interrupt is low.
- R9: A pulse on alarm_evt or update_evt sets its status flag and leaves the interrupt output unchanged.
- R10: A flag event in the same cycle as a status read is missing from that read's data and is still set after the clear.
- R11: Index 0 selects control, 1 selects enable and 2 selects status. Read data appears on the clock after reg_rd. Enable reads back all 8 bits, writes to status are ignored, other indices read 0, and all registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| reg_idx | input | IDX_W | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| alarm_evt | input | 1 | Alarm event pulse |
| update_evt | input | 1 | Update-ended event pulse |
| irq | output | 1 | Registered periodic interrupt |

## Verification
The assertions assume three things about the inputs:
- reg_wr and reg_rd are never high in the same cycle.
- The reset does not coincide with register traffic.
- The summary check relies on status reads happening as one-cycle strobes.

The bench issues every access as a single isolated strobe and keeps ref_tick low around each access. This places every countdown restart before the first counted tick, so the tick counts to expiry are exact. Event pulses are applied only when the test also means to clear status, to check that such a pulse survives the clear.

// File: rtl/rtc_pit_pkg.sv
package rtc_pit_pkg;

  localparam int DATA_W  = 8;
  localparam int RATE_W  = 4;
  localparam int DIV_W   = 3;
  localparam int NCODES  = 2 ** RATE_W;

  localparam int REG_CTRL = 0;
  localparam int REG_EN   = 1;
  localparam int REG_STAT = 2;

  localparam int PIE_BIT  = 6;
  localparam int ST_SUM   = 7;
  localparam int ST_PF    = 6;
  localparam int ST_AF    = 5;
  localparam int ST_UF    = 4;
  localparam int RATE_LSB = 0;
  localparam int DIV_LSB  = 4;

  localparam logic [DIV_W-1:0] DIV_SLOW   = 3'b010;
  localparam logic [DIV_W-1:0] DIV_FAST_A = 3'b001;
  localparam logic [DIV_W-1:0] DIV_FAST_B = 3'b000;

  // Reference ticks per periodic event for a rate code and timebase.
  function automatic int pit_period(input int code, input bit slow, input int ref_hz);
    int shift;
    if (code == 0) return 0;
    shift = (slow && code <= 2) ? 9 - code : 16 - code;
    return ref_hz >> shift;
  endfunction

endpackage

// File: rtl/rtc_pit_regs.sv
module rtc_pit_regs
  import rtc_pit_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] stat_byte,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [RATE_W-1:0] rate_code,
  output logic              slow_tb,
  output logic              pie,
  output logic              reload,
  output logic              irq_off,
  output logic              stat_rd
);

  logic [RATE_W-1:0] rate_q;
  logic [DIV_W-1:0]  div_q;
  logic              slow_q;
  logic [DATA_W-1:0] en_q;
  logic              reload_q;
  logic [DATA_W-1:0] rdata_q;

  logic wr_ctrl, wr_en;
  logic [DIV_W-1:0]  wdiv;
  logic [RATE_W-1:0] wrate;

  assign wr_ctrl = reg_wr && (reg_idx == IDX_W'(REG_CTRL));
  assign wr_en   = reg_wr && (reg_idx == IDX_W'(REG_EN));
  assign stat_rd = reg_rd && (reg_idx == IDX_W'(REG_STAT));
  assign wdiv    = reg_wdata[DIV_LSB +: DIV_W];
  assign wrate   = reg_wdata[RATE_LSB +: RATE_W];
  assign irq_off = wr_en && !reg_wdata[PIE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q   <= '0;
      div_q    <= '0;
      slow_q   <= 1'b0;
      en_q     <= '0;
      reload_q <= 1'b0;
    end else begin
      reload_q <= 1'b0;
      if (wr_ctrl) begin
        rate_q   <= wrate;
        div_q    <= wdiv;
        reload_q <= 1'b1;
        case (wdiv)
          DIV_SLOW:               slow_q <= 1'b1;
          DIV_FAST_A, DIV_FAST_B: slow_q <= 1'b0;
          default:                slow_q <= slow_q;
        endcase
      end
      if (wr_en) begin
        en_q <= reg_wdata;
        if (reg_wdata[PIE_BIT] != en_q[PIE_BIT]) reload_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      if (reg_idx == IDX_W'(REG_CTRL))      rdata_q <= {1'b0, div_q, rate_q};
      else if (reg_idx == IDX_W'(REG_EN))   rdata_q <= en_q;
      else if (reg_idx == IDX_W'(REG_STAT)) rdata_q <= stat_byte;
      else                                  rdata_q <= '0;
    end
  end

  assign reg_rdata = rdata_q;
  assign rate_code = rate_q;
  assign slow_tb   = slow_q;
  assign pie       = en_q[PIE_BIT];
  assign reload    = reload_q;

  AST_CTRL_RELOADS: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> reload); // R4

endmodule

// File: rtl/rtc_pit_rate.sv
module rtc_pit_rate
  import rtc_pit_pkg::*;
#(
  parameter int REF_HZ = 65536,
  parameter int CNT_W  = 16
) (
  input  logic [RATE_W-1:0] rate_code,
  input  logic              slow_tb,
  output logic [CNT_W-1:0]  period
);

  logic [CNT_W-1:0] fast_tab [NCODES];
  logic [CNT_W-1:0] slow_tab [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_code
    localparam int FAST_P = pit_period(g, 1'b0, REF_HZ);
    localparam int SLOW_P = pit_period(g, 1'b1, REF_HZ);
    assign fast_tab[g] = CNT_W'(FAST_P);
    assign slow_tab[g] = CNT_W'(SLOW_P);
  end

  assign period = slow_tb ? slow_tab[rate_code] : fast_tab[rate_code];

  always_comb begin
    AST_RATE0_IDLE: assert (rate_code != '0 || period == '0); // R1
  end

endmodule

// File: rtl/rtc_pit_count.sv
module rtc_pit_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             pie,
  input  logic             reload,
  input  logic [CNT_W-1:0] period,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic             run;

  assign run    = pie && (period != '0) && !reload;
  assign expire = run && ref_tick && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (reload)          cnt_q <= period;
    else if (run && ref_tick) cnt_q <= expire ? period : cnt_q - 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    !reload |-> cnt_q <= period); // R2

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (rst)
    reload |=> cnt_q == $past(period)); // R4

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!pie && !reload) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/rtc_pit_status.sv
module rtc_pit_status
  import rtc_pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              expire,
  input  logic              alarm_evt,
  input  logic              update_evt,
  input  logic              stat_rd,
  input  logic              irq_off,
  output logic [DATA_W-1:0] stat_byte,
  output logic              irq
);

  logic pf_q, af_q, uf_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_q  <= 1'b0;
      af_q  <= 1'b0;
      uf_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (stat_rd) begin
        pf_q <= expire;
        af_q <= alarm_evt;
        uf_q <= update_evt;
      end else begin
        pf_q <= pf_q | expire;
        af_q <= af_q | alarm_evt;
        uf_q <= uf_q | update_evt;
      end
      if (irq_off)      irq_q <= 1'b0;
      else if (expire)  irq_q <= 1'b1;
      else if (stat_rd) irq_q <= 1'b0;
    end
  end

  always_comb begin
    stat_byte         = '0;
    stat_byte[ST_PF]  = pf_q;
    stat_byte[ST_AF]  = af_q;
    stat_byte[ST_UF]  = uf_q;
    stat_byte[ST_SUM] = pf_q | af_q | uf_q;
  end

  assign irq = irq_q;

  AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (rst)
    expire |=> pf_q); // R5

  AST_IRQ_NEEDS_PF: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> pf_q); // R6

  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !expire && !alarm_evt && !update_evt) |=> (stat_byte == '0 && !irq_q)); // R8

  AST_EVT_SURVIVE: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && alarm_evt) |=> af_q); // R10

endmodule

// File: rtl/rtc_pit.sv
module rtc_pit
  import rtc_pit_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int REF_HZ = 65536
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             alarm_evt,
  input  logic             update_evt,
  output logic             irq
);

  localparam int CNT_W = $clog2(REF_HZ / 2 + 1);

  logic [RATE_W-1:0] rate_code;
  logic              slow_tb, pie, reload, irq_off, stat_rd, expire;
  logic [CNT_W-1:0]  period;
  logic [DATA_W-1:0] stat_byte;

  rtc_pit_regs #(.IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst(rst), .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .stat_byte(stat_byte), .reg_rdata(reg_rdata),
    .rate_code(rate_code), .slow_tb(slow_tb), .pie(pie), .reload(reload),
    .irq_off(irq_off), .stat_rd(stat_rd)
  );

  rtc_pit_rate #(.REF_HZ(REF_HZ), .CNT_W(CNT_W)) rate_i (
    .rate_code(rate_code), .slow_tb(slow_tb), .period(period)
  );

  rtc_pit_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .pie(pie), .reload(reload),
    .period(period), .expire(expire)
  );

  rtc_pit_status status_i (
    .clk(clk), .rst(rst), .expire(expire), .alarm_evt(alarm_evt),
    .update_evt(update_evt), .stat_rd(stat_rd), .irq_off(irq_off),
    .stat_byte(stat_byte), .irq(irq)
  );

  AST_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd && reg_idx == IDX_W'(REG_STAT)) |-> (reg_rdata[7] == |reg_rdata[6:4])); // R7

endmodule

// File: tb/rtc_pit_tb_top.sv
module rtc_pit_tb_top;

  localparam int REF_HZ = 32768;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 1'b0;
  logic [1:0] reg_idx = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       alarm_evt = 1'b0;
  logic       update_evt = 1'b0;
  logic       irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_pit #(.IDX_W(2), .REF_HZ(REF_HZ)) dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .reg_idx(reg_idx),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_evt(alarm_evt), .update_evt(update_evt),
    .irq(irq)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      ref_tick = 1'b1;
      repeat (n) @(negedge clk);
      ref_tick = 1'b0;
    end
  endtask

  function automatic int exp_period(input int code, input bit slow);
    int hz;
    if (code == 0) return 0;
    if (code <= 2) hz = slow ? (512 >> code) : (65536 >> code);
    else           hz = 65536 >> code;
    return REF_HZ / hz;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int p;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    check("R11 reset irq", irq, 0);
    rd(2'd0, d); check("R11 reset ctrl", d, 8'h00);
    rd(2'd1, d); check("R11 reset enable", d, 8'h00);
    rd(2'd2, d); check("R11 reset status", d, 8'h00);

    // R1: rate 0 stays idle
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h00);
    ticks(500);
    check("R1 rate0 irq", irq, 0);
    rd(2'd2, d); check("R1 rate0 status", d, 8'h00);

    // R2 / R3 / R5 sweep over both timebases
    for (int s = 0; s < 2; s++) begin
      for (int c = 1; c < 16; c++) begin
        logic [2:0] dv;
        dv = (s == 1) ? 3'b010 : ((c % 2 == 1) ? 3'b001 : 3'b000);
        wr(2'd0, {1'b0, dv, 4'(c)});
        rd(2'd2, d);
        p = exp_period(c, s == 1);
        ticks(p - 1);
        check($sformatf("R2 R3 code %0d slow %0d early", c, s), irq, 0);
        ticks(1);
        check($sformatf("R2 R3 code %0d slow %0d expiry", c, s), irq, 1);
        rd(2'd2, d);
        check($sformatf("R5 R7 code %0d status", c), d, 8'hC0);
        check($sformatf("R8 code %0d irq cleared", c), irq, 0);
        if (s == 0) begin
          ticks(p - 1);
          check($sformatf("R5 code %0d second early", c), irq, 0);
          ticks(1);
          check($sformatf("R5 code %0d second expiry", c), irq, 1);
          rd(2'd2, d);
        end
      end
    end

    // R3: other divider values keep the timebase
    wr(2'd0, 8'h21);
    wr(2'd0, 8'h71);
    rd(2'd2, d);
    ticks(127);
    check("R3 keep slow early", irq, 0);
    ticks(1);
    check("R3 keep slow expiry", irq, 1);
    rd(2'd2, d);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h71);
    rd(2'd2, d);
    ticks(1);
    check("R3 keep fast expiry", irq, 1);
    rd(2'd2, d);
    rd(2'd0, d); check("R4 ctrl readback", d, 8'h71);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R4 ctrl bit7 dropped", d, 8'h7F);

    // R4: rewrite mid-count restarts
    wr(2'd0, 8'h03);
    rd(2'd2, d);
    ticks(2);
    wr(2'd0, 8'h03);
    ticks(3);
    check("R4 restart early", irq, 0);
    ticks(1);
    check("R4 restart expiry", irq, 1);
    rd(2'd2, d);

    // R5: disabled countdown does not run, enabling restarts it
    wr(2'd1, 8'h00);
    ticks(10);
    check("R5 disabled irq", irq, 0);
    rd(2'd2, d); check("R5 disabled status", d, 8'h00);
    wr(2'd1, 8'h40);
    ticks(3);
    check("R6 enable restart early", irq, 0);
    ticks(1);
    check("R6 enable restart expiry", irq, 1);
    rd(2'd2, d);

    // R6: write keeping bit 6 does not restart
    ticks(2);
    wr(2'd1, 8'h41);
    ticks(2);
    check("R6 same enable no restart", irq, 1);
    rd(2'd2, d);
    rd(2'd1, d); check("R11 enable readback", d, 8'h41);
    ticks(4);
    check("R6 pre-disable irq", irq, 1);
    wr(2'd1, 8'h01);
    check("R6 disable drops irq", irq, 0);
    rd(2'd2, d); check("R6 flag kept", d, 8'hC0);

    // R9 / R7: external flags
    @(negedge clk); alarm_evt = 1'b1;
    @(negedge clk); alarm_evt = 1'b0;
    check("R9 alarm no irq", irq, 0);
    rd(2'd2, d); check("R9 R7 alarm status", d, 8'hA0);
    @(negedge clk); update_evt = 1'b1;
    @(negedge clk); update_evt = 1'b0;
    check("R9 update no irq", irq, 0);
    rd(2'd2, d); check("R9 R7 update status", d, 8'h90);
    rd(2'd2, d); check("R8 status cleared", d, 8'h00);

    // R10: event during status read survives
    @(negedge clk); update_evt = 1'b1;
    @(negedge clk); update_evt = 1'b0;
    reg_idx = 2'd2; reg_rd = 1'b1; alarm_evt = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; alarm_evt = 1'b0;
    check("R10 read data", reg_rdata, 8'h90);
    rd(2'd2, d); check("R10 survivor", d, 8'hA0);

    // R11: status writes ignored, unused index reads 0
    wr(2'd2, 8'hFF);
    rd(2'd2, d); check("R11 status write ignored", d, 8'h00);
    check("R11 status write irq", irq, 0);
    rd(2'd3, d); check("R11 unused index", d, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule